// File: doc/BRIEF.md
# Test Access Port Controller with Shared Pad Ownership

This block holds the sixteen-state test access port (TAP) sequencer and the logic that decides who owns the pads shared between test and user logic. TMS always belongs to the TAP. The TDI, TCK and TDO pads can serve either the TAP or user logic. A static `mode_dedicated` input sets this. When it is high, those pads always carry test functions. When it is low (shared operation), the pads belong to user logic while the sequencer rests in its reset state, and they pass to the TAP once a TCK rising edge moves the sequencer out of that state.

A second static input, `reserve_trst`, decides whether the TRST pad acts as an active-low asynchronous test reset or stays as ordinary user I/O. If it stays user I/O, the pad's output enable comes from user logic, so an unused pad remains tristated. The block also registers the serial test data onto TDO on the falling edge of TCK and drives an output enable for TDO.

The block is clocked only by TCK. The configuration inputs are expected to change only while the power-on reset is active. No stream data passes through the block, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `tap_pad_ctrl`

## Requirements
- R1: While `por_n` is low, `tap_state` is 0 (Test-Logic-Reset), `tdo_oe` is 0, and in shared mode `pad_jtag_sel` is 3'b000.
- R2: On each TCK rising edge the sequencer follows the standard TAP table with TMS, using these codes: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.
- R3: Five successive TCK rising edges with TMS high bring the sequencer to state 0 from any state. After four such edges starting from Shift-DR, the state is not 0.
- R4: In shared mode (`mode_dedicated`=0), `pad_jtag_sel` is 3'b000 while `tap_state` is 0 and 3'b111 in every other state. It changes on the same TCK rising edge that changes the state. Bit 0 selects TDI, bit 1 selects TCK, bit 2 selects TDO, and a 1 gives the pad to the TAP.
- R5: In dedicated mode (`mode_dedicated`=1), `pad_jtag_sel` is 3'b111 in every state, including state 0.
- R6: With `reserve_trst`=1, a low `trst_n` forces state 0 at once and holds it there even on TCK edges with TMS low. In this case `trst_is_reset` is 1 and `trst_pad_oe` is 0.
- R7: With `reserve_trst`=0, `trst_n` has no effect on the sequencer, `trst_is_reset` is 0, and `trst_pad_oe` follows `user_trst_oe`.
- R8: `tdo_oe` is 1 only while the state is Shift-DR or Shift-IR. Both `tdo_oe` and `tdo` change only on TCK falling edges, and `tdo` takes the value `shift_data` has at that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the sequencer steps on the rising edge |
| por_n | input | 1 | Active-low power-on reset |
| tms | input | 1 | Test mode select |
| trst_n | input | 1 | TRST pad level; a test reset only when reserved |
| mode_dedicated | input | 1 | 1 = pads always owned by the TAP, 0 = shared |
| reserve_trst | input | 1 | 1 = TRST pad acts as the test reset |
| user_trst_oe | input | 1 | User output enable for the TRST pad |
| shift_data | input | 1 | Serial data from the selected test register |
| pad_jtag_sel | output | 3 | Per-pad owner: [0] TDI, [1] TCK, [2] TDO; 1 = TAP |
| tdo | output | 1 | Registered test data out |
| tdo_oe | output | 1 | TDO pad output enable |
| trst_is_reset | output | 1 | TRST pad is used as the test reset |
| trst_pad_oe | output | 1 | TRST pad output enable |
| tap_state | output | 4 | Current sequencer state code |

## Verification
A test reset on a reserved TRST pad can arrive in the same cycle as a TCK rising edge with TMS low, which would otherwise take the sequencer out of Test-Logic-Reset and hand the pads to the TAP. The bench holds `trst_n` low across such an edge. It then checks that the state stays 0 and that the pad selects stay with user logic. A second case checks that exit happens on the first edge after `trst_n` is released. It also lines up a change of serial data against the rising edge and then the falling edge in Shift-DR, to confirm that TDO moves only on the falling edge.

// File: rtl/tap_pad_pkg.sv
package tap_pad_pkg;
  localparam int STATE_W = 4;
  localparam int NUM_SHARED = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PA_DR   = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PA_IR   = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;
endpackage

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pad_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  state_d = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  state_d = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  // R2: leaving the reset state with TMS low always lands in Run-Test/Idle
  a_r2_leave_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_RESET && !tms) |=> (state_q == ST_IDLE));

  // R3: TMS high in Select-IR always completes the return to reset
  a_r3_sel_ir_exit: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_SEL_IR && tms) |=> (state_q == ST_RESET));
endmodule

// File: rtl/tap_pad_owner.sv
module tap_pad_owner
  import tap_pad_pkg::*;
#(
  parameter int PADS = NUM_SHARED
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            mode_dedicated,
  input  logic            leave_reset_d,
  output logic [PADS-1:0] sel
);
  logic test_owned_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) test_owned_q <= 1'b0;
    else        test_owned_q <= leave_reset_d;
  end

  for (genvar p = 0; p < PADS; p++) begin : g_pad
    assign sel[p] = mode_dedicated | test_owned_q;
  end
endmodule

// File: rtl/tap_tdo_stage.sv
module tap_tdo_stage
  import tap_pad_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state_q,
  input  logic       shift_data,
  output logic       tdo,
  output logic       tdo_oe
);
  logic in_shift;
  assign in_shift = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= shift_data;
      tdo_oe <= in_shift;
    end
  end
endmodule

// File: rtl/tap_pad_ctrl.sv
module tap_pad_ctrl
  import tap_pad_pkg::*;
(
  input  logic                  tck,
  input  logic                  por_n,
  input  logic                  tms,
  input  logic                  trst_n,
  input  logic                  mode_dedicated,
  input  logic                  reserve_trst,
  input  logic                  user_trst_oe,
  input  logic                  shift_data,
  output logic [NUM_SHARED-1:0] pad_jtag_sel,
  output logic                  tdo,
  output logic                  tdo_oe,
  output logic                  trst_is_reset,
  output logic                  trst_pad_oe,
  output logic [STATE_W-1:0]    tap_state
);
  logic       rst_n_eff;
  tap_state_e state_q;
  tap_state_e state_d;

  assign rst_n_eff     = por_n & ~(reserve_trst & ~trst_n);
  assign trst_is_reset = reserve_trst;
  assign trst_pad_oe   = reserve_trst ? 1'b0 : user_trst_oe;
  assign tap_state     = state_q;

  tap_seq u_seq (
    .tck     (tck),
    .rst_n   (rst_n_eff),
    .tms     (tms),
    .state_q (state_q),
    .state_d (state_d)
  );

  tap_pad_owner #(.PADS(NUM_SHARED)) u_owner (
    .tck            (tck),
    .rst_n          (rst_n_eff),
    .mode_dedicated (mode_dedicated),
    .leave_reset_d  (state_d != ST_RESET),
    .sel            (pad_jtag_sel)
  );

  tap_tdo_stage u_tdo (
    .tck        (tck),
    .rst_n      (rst_n_eff),
    .state_q    (state_q),
    .shift_data (shift_data),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe)
  );

  // R4: away from reset the shared pads always belong to the TAP
  a_r4_owned_off_reset: assert property (@(posedge tck) disable iff (!rst_n_eff)
    (state_q != ST_RESET) |-> (&pad_jtag_sel));

  // R4: in shared mode the reset state hands the pads to user logic
  a_r4_user_in_reset: assert property (@(posedge tck) disable iff (!rst_n_eff)
    (!mode_dedicated && state_q == ST_RESET) |-> (pad_jtag_sel == '0));

  // R5: dedicated mode never releases a pad
  a_r5_dedicated_owned: assert property (@(posedge tck) disable iff (!por_n)
    mode_dedicated |-> (&pad_jtag_sel));

  // R6: an asserted reserved test reset pins the sequencer in reset
  a_r6_trst_holds: assert property (@(posedge tck) disable iff (!por_n)
    (reserve_trst && !trst_n) |-> (state_q == ST_RESET));

  // R8: TDO is only enabled while the TDO pad is with the TAP
  a_r8_oe_needs_pad: assert property (@(posedge tck) disable iff (!rst_n_eff)
    tdo_oe |-> pad_jtag_sel[2]);
endmodule

// File: tb/tap_pad_ctrl_tb.sv
`timescale 1ns/1ps
module tap_pad_ctrl_tb_top;
  logic       tck = 1'b0;
  logic       por_n = 1'b0;
  logic       tms = 1'b1;
  logic       trst_n = 1'b1;
  logic       mode_dedicated = 1'b0;
  logic       reserve_trst = 1'b0;
  logic       user_trst_oe = 1'b0;
  logic       shift_data = 1'b0;
  logic [2:0] pad_jtag_sel;
  logic       tdo, tdo_oe, trst_is_reset, trst_pad_oe;
  logic [3:0] tap_state;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 tck = ~tck;

  tap_pad_ctrl dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .trst_n(trst_n),
    .mode_dedicated(mode_dedicated), .reserve_trst(reserve_trst),
    .user_trst_oe(user_trst_oe), .shift_data(shift_data),
    .pad_jtag_sel(pad_jtag_sel), .tdo(tdo), .tdo_oe(tdo_oe),
    .trst_is_reset(trst_is_reset), .trst_pad_oe(trst_pad_oe),
    .tap_state(tap_state)
  );

  // {tms, expected state after the rising edge}, starting from state 0
  localparam logic [4:0] VEC [25] = '{
    5'b0_0001, 5'b0_0001, 5'b1_0010, 5'b0_0011, 5'b0_0100,
    5'b0_0100, 5'b1_0101, 5'b0_0110, 5'b0_0110, 5'b1_0111,
    5'b0_0100, 5'b1_0101, 5'b1_1000, 5'b1_0010, 5'b1_1001,
    5'b0_1010, 5'b0_1011, 5'b1_1100, 5'b0_1101, 5'b1_1110,
    5'b1_1111, 5'b0_0001, 5'b1_0010, 5'b1_1001, 5'b1_0000
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive TMS after a falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic t);
    @(negedge tck); #0.5 tms = t;
    @(posedge tck); #1;
  endtask

  task automatic power_on(input logic ded, input logic res);
    @(negedge tck); #0.5;
    por_n = 1'b0; tms = 1'b1; trst_n = 1'b1;
    mode_dedicated = ded; reserve_trst = res;
    repeat (2) @(posedge tck);
    #1;
    chk("R1 state", tap_state, 0);
    chk("R1 tdo_oe", tdo_oe, 0);
    if (!ded) chk("R1 sel", pad_jtag_sel, 0);
    @(negedge tck); #0.5 por_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1, R2, R4: table walk in shared mode, trst not reserved
    power_on(1'b0, 1'b0);
    foreach (VEC[i]) begin
      step(VEC[i][4]);
      chk("R2 state", tap_state, VEC[i][3:0]);
      chk("R4 sel", pad_jtag_sel, (VEC[i][3:0] == 4'd0) ? 3'b000 : 3'b111);
    end

    // R8: TDO timing in Shift-DR
    step(1'b0); step(1'b1); step(1'b0); step(1'b0);
    chk("R2 reach shift", tap_state, 4);
    chk("R8 oe before fall", tdo_oe, 0);
    shift_data = 1'b1;
    @(negedge tck); #0.5;
    chk("R8 oe in shift", tdo_oe, 1);
    chk("R8 tdo captured", tdo, 1);
    shift_data = 1'b0; tms = 1'b0;
    @(posedge tck); #1;
    chk("R8 tdo holds at rise", tdo, 1);
    @(negedge tck); #0.5;
    chk("R8 tdo at fall", tdo, 0);

    // R3: four TMS-high edges from Shift-DR stay out of reset, fifth returns
    for (int k = 0; k < 4; k++) step(1'b1);
    chk("R3 four edges", tap_state, 9);
    chk("R8 oe off", tdo_oe, 0);
    step(1'b1);
    chk("R3 five edges", tap_state, 0);
    chk("R4 sel back to user", pad_jtag_sel, 0);

    // R7: unreserved trst has no effect
    step(1'b0);
    chk("R7 in idle", tap_state, 1);
    trst_n = 1'b0;
    step(1'b0);
    chk("R7 trst ignored", tap_state, 1);
    chk("R7 is_reset", trst_is_reset, 0);
    user_trst_oe = 1'b1; #0.1;
    chk("R7 oe follows 1", trst_pad_oe, 1);
    user_trst_oe = 1'b0; #0.1;
    chk("R7 oe follows 0", trst_pad_oe, 0);

    // R6: reserved trst forces and holds reset, beating a TMS-low edge
    power_on(1'b0, 1'b1);
    step(1'b0); step(1'b1); step(1'b0);
    chk("R2 cap_dr", tap_state, 3);
    #0.5 trst_n = 1'b0; #0.5;
    chk("R6 async reset", tap_state, 0);
    chk("R6 sel user", pad_jtag_sel, 0);
    step(1'b0);
    chk("R6 holds on tms low", tap_state, 0);
    chk("R6 sel held", pad_jtag_sel, 0);
    user_trst_oe = 1'b1; #0.1;
    chk("R6 pad oe", trst_pad_oe, 0);
    chk("R6 is_reset", trst_is_reset, 1);
    user_trst_oe = 1'b0;
    @(negedge tck); #0.5 trst_n = 1'b1;
    step(1'b0);
    chk("R6 release exits", tap_state, 1);

    // R5: dedicated mode keeps all pads with the TAP
    power_on(1'b1, 1'b0);
    #2;
    chk("R5 sel in reset", pad_jtag_sel, 7);
    step(1'b0);
    chk("R5 sel idle", pad_jtag_sel, 7);
    for (int k = 0; k < 5; k++) step(1'b1);
    chk("R3 dedicated return", tap_state, 0);
    chk("R5 sel after return", pad_jtag_sel, 7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule